// File: doc/BRIEF.md
# Hall Commutation PWM Gate Driver

This block drives a three-phase half-bridge, one upper and one lower FET per phase, from three digital Hall sensor levels. A fixed six-step table turns each Hall code into one sourcing phase, one sinking phase and one floating phase. A direction input chooses between the table and the same table indexed with every Hall bit inverted. The sourcing phase's upper FET is chopped by a carrier-synchronous PWM. In the off part of each period that phase's lower FET conducts, so the recirculating current flows through a switched channel rather than through a body diode.

A start/stop input and a stop-mode select give three conditions: run, free run (every gate off) and short-circuit braking (every lower FET on). A protection flag removes all upper drive. A current-limit trip cuts the rest of the present PWM period, but only after it has stayed asserted through a blanking window, so that reverse-recovery spikes do not cut the pulse. Every gate passes through a per-phase dead-time stage, so the two FETs of a phase are never on together.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_fwd_i` high, the synchronised Hall code written as sensor1,sensor2,sensor3 (`hall_i[2]`,`hall_i[1]`,`hall_i[0]`) sets the phases 1,2,3 (gate bit 2,1,0) as source/sink/float: 101→sink,source,float; 100→sink,float,source; 110→float,sink,source; 010→source,sink,float; 011→source,float,sink; 001→float,source,sink.
- R2: With `dir_fwd_i` low, the R1 table is indexed with all three Hall bits inverted.
- R3: While running, Hall codes 000 and 111 turn all six gates off.
- R4: While running, a sinking phase holds its lower gate on and a floating phase holds both gates off. A sourcing phase has its upper gate on for `duty_i − dead_i` cycles of each carrier period and its lower gate on for the rest, less one dead time. A duty of 0 keeps its upper gate off.
- R5: The upper and lower gate of a phase are never on in the same cycle. Each hand-over between them leaves both off for max(`dead_i`,1) cycles.
- R6: With `stop_i` high and `coast_sel_i` high, all six gates are off from the next cycle.
- R7: With `stop_i` high and `coast_sel_i` low, all lower gates are on and all upper gates off, whatever the Hall code and `prot_i`.
- R8: While running with `prot_i` high, every upper gate is off from the next cycle, the sourcing phase's lower gate is also off, and the sinking phase's lower gate stays on.
- R9: A trip on `ilim_trip_i` that lasts fewer than BLANK_CYC consecutive cycles has no effect on the gates.
- R10: A trip held for BLANK_CYC consecutive cycles ends upper drive for the rest of the carrier period, even if the trip is released. Drive resumes after the next `carrier_tick_i`.
- R11: While `rst_n` is low, all gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall levels, bit 2 = sensor 1, bit 0 = sensor 3 |
| dir_fwd_i | input | 1 | 1 = forward table, 0 = inverted-Hall indexing |
| stop_i | input | 1 | 1 = stop, 0 = run |
| coast_sel_i | input | 1 | Stop mode: 1 = free run, 0 = short-circuit brake |
| carrier_tick_i | input | 1 | One-cycle pulse that starts a PWM period |
| duty_i | input | CNT_W | Upper-gate request length in cycles per period |
| ilim_trip_i | input | 1 | Raw current-limit comparator |
| prot_i | input | 1 | Constraint protection active |
| dead_i | input | DT_W | Dead time in cycles |
| hi_o | output | 3 | Upper gate enables, bit 2 = phase 1 |
| lo_o | output | 3 | Lower gate enables, bit 2 = phase 1 |

## Verification
The bench builds the block with CNT_W=6, DT_W=4, BLANK_CYC=5 and SYNC_STAGES=2, and drives a 40-cycle carrier. A 5-cycle blanking window lets a 4-cycle trip burst run right at the limit, and a sustained trip followed by release lands inside a single period. A 6-bit duty lets the value 63 outrun the carrier and hold the upper gate on, so the table entries can be read as steady levels. The dead time can be set to 0 and to 3 in the same run, which shows both the one-cycle minimum gap and an exact programmed gap.

// File: rtl/bldc_drv_pkg.sv
package bldc_drv_pkg;

  // Role a phase plays in the present commutation step
  typedef enum logic [1:0] {
    PH_FLOAT = 2'd0,
    PH_SRC   = 2'd1,
    PH_SINK  = 2'd2
  } phase_mode_e;

  localparam int unsigned NUM_PH = 3;

endpackage

// File: rtl/bldc_hall_sync.sv
module bldc_hall_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bldc_step_decode.sv
module bldc_step_decode
  import bldc_drv_pkg::*;
(
  input  logic                   fwd_i,
  input  logic [2:0]             hall_i,
  output phase_mode_e [2:0]      mode_o,
  output logic                   valid_o
);

  logic [2:0] idx;

  always_comb begin
    idx       = fwd_i ? hall_i : ~hall_i;
    valid_o   = 1'b1;
    mode_o[2] = PH_FLOAT;
    mode_o[1] = PH_FLOAT;
    mode_o[0] = PH_FLOAT;
    unique case (idx)
      3'b101: begin mode_o[2] = PH_SINK;  mode_o[1] = PH_SRC;   mode_o[0] = PH_FLOAT; end
      3'b100: begin mode_o[2] = PH_SINK;  mode_o[1] = PH_FLOAT; mode_o[0] = PH_SRC;   end
      3'b110: begin mode_o[2] = PH_FLOAT; mode_o[1] = PH_SINK;  mode_o[0] = PH_SRC;   end
      3'b010: begin mode_o[2] = PH_SRC;   mode_o[1] = PH_SINK;  mode_o[0] = PH_FLOAT; end
      3'b011: begin mode_o[2] = PH_SRC;   mode_o[1] = PH_FLOAT; mode_o[0] = PH_SINK;  end
      3'b001: begin mode_o[2] = PH_FLOAT; mode_o[1] = PH_SRC;   mode_o[0] = PH_SINK;  end
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bldc_pwm_gen.sv
module bldc_pwm_gen #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BLANK_CYC = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             trip_i,
  output logic             pwm_on_o
);

  localparam int unsigned BLK_W = $clog2(BLANK_CYC + 1);
  localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(BLANK_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BLK_W-1:0] blank_q, blank_n;
  logic             cut_q, cut_n;
  logic             pwm_q, pwm_n;
  logic             trip_hit;

  always_comb begin
    if (tick_i)              cnt_n = '0;
    else if (cnt_q != '1)    cnt_n = cnt_q + 1'b1;
    else                     cnt_n = cnt_q;

    if (!trip_i)               blank_n = '0;
    else if (blank_q != BLK_MAX) blank_n = blank_q + 1'b1;
    else                       blank_n = blank_q;

    trip_hit = (blank_n == BLK_MAX);
    cut_n    = tick_i ? 1'b0 : (cut_q | trip_hit);
    pwm_n    = (cnt_n < duty_i) && !cut_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blank_q <= '0;
      cut_q   <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      blank_q <= blank_n;
      cut_q   <= cut_n;
      pwm_q   <= pwm_n;
    end
  end

  assign pwm_on_o = pwm_q;

  // R9
  trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cut_q) |-> $past(trip_i));

  // R10
  cut_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && !tick_i) |=> !pwm_q);

endmodule

// File: rtl/bldc_dead_gate.sv
module bldc_dead_gate #(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_req_i,
  input  logic            dn_req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);

  logic            hi_q, hi_n;
  logic            lo_q, lo_n;
  logic [DT_W-1:0] off_q, off_n;
  logic            off_ok;

  always_comb begin
    off_ok = ({1'b0, off_q} + {{DT_W{1'b0}}, 1'b1}) >= {1'b0, dead_i};
    hi_n   = up_req_i && (hi_q || (!lo_q && off_ok));
    lo_n   = dn_req_i && !up_req_i && (lo_q || (!hi_q && off_ok));
    if (hi_q || lo_q)     off_n = '0;
    else if (off_q != '1) off_n = off_q + 1'b1;
    else                  off_n = off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      off_q <= '0;
    end else begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      off_q <= off_n;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));

  // R5
  hi_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> !$past(lo_q));

  // R5
  lo_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> !$past(hi_q));

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_drv_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned DT_W        = 4,
  parameter int unsigned BLANK_CYC   = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hall_i,
  input  logic             dir_fwd_i,
  input  logic             stop_i,
  input  logic             coast_sel_i,
  input  logic             carrier_tick_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             ilim_trip_i,
  input  logic             prot_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [2:0]       hi_o,
  output logic [2:0]       lo_o
);

  logic [2:0]        hall_s;
  phase_mode_e [2:0] mode;
  logic              step_ok;
  logic              pwm_on;
  logic [2:0]        up_req;
  logic [2:0]        dn_req;

  bldc_hall_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hall_i),
    .q_o   (hall_s)
  );

  bldc_step_decode u_dec (
    .fwd_i   (dir_fwd_i),
    .hall_i  (hall_s),
    .mode_o  (mode),
    .valid_o (step_ok)
  );

  bldc_pwm_gen #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (carrier_tick_i),
    .duty_i   (duty_i),
    .trip_i   (ilim_trip_i),
    .pwm_on_o (pwm_on)
  );

  // Gate requests per phase, before dead-time shaping
  always_comb begin
    for (int p = 0; p < int'(NUM_PH); p++) begin
      up_req[p] = 1'b0;
      dn_req[p] = 1'b0;
      if (stop_i) begin
        dn_req[p] = !coast_sel_i;
      end else if (step_ok) begin
        unique case (mode[p])
          PH_SRC: begin
            up_req[p] = pwm_on && !prot_i;
            dn_req[p] = !pwm_on && !prot_i;
          end
          PH_SINK:  dn_req[p] = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  for (genvar p = 0; p < int'(NUM_PH); p++) begin : g_phase
    bldc_dead_gate #(.DT_W(DT_W)) u_dt (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_req_i (up_req[p]),
      .dn_req_i (dn_req[p]),
      .dead_i   (dead_i),
      .hi_o     (hi_o[p]),
      .lo_o     (lo_o[p])
    );
  end

  // R8
  prot_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_i |=> (hi_o == 3'b000));

  // R6
  coast_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && coast_sel_i) |=> (hi_o == 3'b000 && lo_o == 3'b000));

  // R7
  brake_no_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !coast_sel_i) |=> (hi_o == 3'b000));

  // R3
  bad_hall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && (hall_s == 3'b000 || hall_s == 3'b111)) |=> (hi_o == 3'b000 && lo_o == 3'b000));

endmodule

// File: tb/bldc_commutator_tb.sv
module bldc_commutator_tb;

  localparam int CNT_W  = 6;
  localparam int DT_W   = 4;
  localparam int BLANK  = 5;
  localparam int PERIOD = 40;

  logic             clk;
  logic             rst_n;
  logic [2:0]       hall;
  logic             fwd, stop, coast, tick, trip, prot;
  logic [CNT_W-1:0] duty;
  logic [DT_W-1:0]  dead;
  logic [2:0]       hi, lo;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bldc_commutator #(.CNT_W(CNT_W), .DT_W(DT_W), .BLANK_CYC(BLANK), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_fwd_i(fwd), .stop_i(stop),
    .coast_sel_i(coast), .carrier_tick_i(tick), .duty_i(duty), .ilim_trip_i(trip),
    .prot_i(prot), .dead_i(dead), .hi_o(hi), .lo_o(lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Carrier: one tick every PERIOD cycles, changed on the falling edge
  initial begin
    int pc;
    pc   = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = (pc == 0);
      pc   = (pc == PERIOD - 1) ? 0 : pc + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Vector: {req, hall, fwd, stop, coast, prot, full_duty, exp_hi, exp_lo}
  localparam int NV = 19;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1, 3'b101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 3'b100}, // R1
    {4'd1, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 3'b100}, // R1
    {4'd1, 3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 3'b010}, // R1
    {4'd1, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 3'b010}, // R1
    {4'd1, 3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 3'b001}, // R1
    {4'd1, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 3'b001}, // R1
    {4'd4, 3'b101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 3'b110}, // R4
    {4'd4, 3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 3'b101}, // R4
    {4'd2, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 3'b100}, // R2
    {4'd2, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 3'b001}, // R2
    {4'd2, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b001, 3'b010}, // R2
    {4'd3, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000}, // R3
    {4'd3, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000}, // R3
    {4'd6, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000}, // R6
    {4'd7, 3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'b000, 3'b111}, // R7
    {4'd7, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'b000, 3'b111}, // R7
    {4'd7, 3'b101, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 3'b111}, // R7
    {4'd8, 3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'b000, 3'b100}, // R8
    {4'd8, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 3'b010}  // R8
  };

  // Count cycles with phase-1 upper (or lower) gate on over one carrier period
  task automatic count_period(output int nh, output int nl);
    nh = 0;
    nl = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      nh += int'(hi[2]);
      nl += int'(lo[2]);
    end
  endtask

  // Both-off cycles between phase-1 upper turning off and lower turning on
  task automatic gap_hi_to_lo(output int g);
    logic prev;
    int   guard;
    prev  = hi[2];
    guard = 0;
    g     = 0;
    while (!(prev && !hi[2]) && guard < 200) begin
      prev = hi[2];
      @(negedge clk);
      guard++;
    end
    while (!lo[2] && !hi[2] && guard < 400) begin
      g++;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic gap_lo_to_hi(output int g);
    logic prev;
    int   guard;
    prev  = lo[2];
    guard = 0;
    g     = 0;
    while (!(prev && !lo[2]) && guard < 200) begin
      prev = lo[2];
      @(negedge clk);
      guard++;
    end
    while (!lo[2] && !hi[2] && guard < 400) begin
      g++;
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int nh, nl, g;
    rst_n = 1'b0;
    hall  = 3'b101;
    fwd   = 1'b1;
    stop  = 1'b0;
    coast = 1'b1;
    trip  = 1'b0;
    prot  = 1'b0;
    duty  = '1;
    dead  = 4'd2;

    // R11: gates off while reset is held, even with a drive pattern applied
    repeat (4) @(negedge clk);
    check("R11", "hi in reset", int'(hi), 0);
    check("R11", "lo in reset", int'(lo), 0);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      hall  = VEC[v][13:11];
      fwd   = VEC[v][10];
      stop  = VEC[v][9];
      coast = VEC[v][8];
      prot  = VEC[v][7];
      duty  = VEC[v][6] ? '1 : '0;
      repeat (30) @(negedge clk);
      check($sformatf("R%0d", int'(VEC[v][17:14])), $sformatf("vec%0d hi", v), int'(hi), int'(VEC[v][5:3]));
      check($sformatf("R%0d", int'(VEC[v][17:14])), $sformatf("vec%0d lo", v), int'(lo), int'(VEC[v][2:0]));
    end

    // R4 / R5: duty 20, dead 3 on source phase 1 (Hall 010 forward)
    @(negedge clk);
    hall = 3'b010; fwd = 1'b1; stop = 1'b0; coast = 1'b1; prot = 1'b0;
    duty = 6'd20; dead = 4'd3;
    repeat (3 * PERIOD) @(negedge clk);
    count_period(nh, nl);
    check("R4", "upper on-cycles duty20 dead3", nh, 17);
    check("R4", "lower on-cycles duty20 dead3", nl, 17);
    gap_hi_to_lo(g);
    check("R5", "gap upper->lower dead3", g, 3);
    gap_lo_to_hi(g);
    check("R5", "gap lower->upper dead3", g, 3);
    check("R4", "sink phase 2 lower held", int'(lo[1]), 1);

    @(negedge clk);
    dead = 4'd0;
    repeat (3 * PERIOD) @(negedge clk);
    gap_hi_to_lo(g);
    check("R5", "gap upper->lower dead0", g, 1);
    gap_lo_to_hi(g);
    check("R5", "gap lower->upper dead0", g, 1);

    // R9: 4-cycle trip bursts across a whole period leave the pulse intact
    @(negedge clk);
    duty = 6'd30; dead = 4'd2;
    repeat (3 * PERIOD) @(negedge clk);
    count_period(nh, nl);
    check("R4", "upper on-cycles duty30 dead2", nh, 28);
    @(posedge clk iff tick);
    fork
      count_period(nh, nl);
      begin
        for (int k = 0; k < 5; k++) begin
          @(negedge clk); trip = 1'b1;
          repeat (3) @(negedge clk);
          @(negedge clk); trip = 1'b0;
          repeat (3) @(negedge clk);
        end
      end
    join
    trip = 1'b0;
    check("R9", "upper on-cycles with short trips", nh, 28);

    // R10: sustained trip, released mid-period, drive returns only after next tick
    repeat (2 * PERIOD) @(negedge clk);
    @(posedge clk iff tick);
    @(negedge clk);
    trip = 1'b1;
    repeat (20) @(negedge clk);
    check("R10", "upper off under sustained trip", int'(hi[2]), 0);
    trip = 1'b0;
    nh = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      nh += int'(hi[2]);
    end
    check("R10", "upper stays off after release", nh, 0);
    @(posedge clk iff tick);
    repeat (6) @(negedge clk);
    check("R10", "upper resumes next period", int'(hi[2]), 1);

    // R11: reset in the middle of active drive
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11", "hi after async reset", int'(hi), 0);
    check("R11", "lo after async reset", int'(lo), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule